// File: doc/BRIEF.md
# Serial Audio Word Transmitter

This block takes 32-bit parallel audio samples and sends them out on a three-wire serial audio bus: a bit clock, a word select that marks the left and right channel, and a data line. Each sample is held in a one-entry holding register and accepted through a valid/ready handshake. When a new channel slot starts, the sample is moved into a shift register and sent MSB first. The bit clock toggles on every system clock, so one bit period lasts two system clocks.

Static configuration inputs choose several things. They set the data word length. They set where the word sits in the 32-bit sample, either at the top or at the bottom. They set whether the first data bit lags the word-select edge by one bit. They also select a compressed mode. Compressed mode always sends with no lag and can add burst clocking. In burst clocking the bit clock only pulses while real data bits are on the line, and it stops when no sample is waiting. In normal mode every slot is 32 bits long. If no sample is ready at a slot boundary, the last word is sent again and a sticky underflow flag is raised.

Configuration is meant to change only while the block is held in reset.

Top module: `sat_tx`

## Requirements
- R1: The length code `cfg_len_code` selects the word length N: 3'b010 gives 18 bits, 3'b011 gives 20, 3'b100 gives 22, 3'b101 gives 24, and 3'b110 or any other code gives 32.
- R2: With `cfg_right_just`=0, the word sent is sample bits 31 down to 32−N. The lower bits have no effect on the line. For example, N=20 sends bits 31..12.
- R3: With `cfg_right_just`=1, the word sent is sample bits N−1 down to 0. The upper bits have no effect on the line. For example, N=20 sends bits 19..0. At N=32 the alignment input is ignored and all 32 bits are sent.
- R4: Words are sent MSB first. `sdata` and `wsel` change only when `bclk` falls, or when the block leaves its idle wait. `bclk` has a period of two system clocks while it runs.
- R5: In normal mode each channel slot is 32 bit periods long. `wsel` is 0 for the left slot and 1 for the right slot, and the slots alternate starting with left. `sdata` is 0 for the slot positions after the N data bits.
- R6: Outside compressed mode, `cfg_zero_delay`=0 puts the MSB one bit period after the `wsel` change. `cfg_zero_delay`=1 puts the MSB in the same bit period as the change.
- R7: With `cfg_compress`=1, `cfg_zero_delay` is ignored and the MSB always shares its bit period with the `wsel` change.
- R8: With `cfg_compress`=1 and `cfg_burst`=1, each slot is N bit periods long and `bclk` gives exactly N rising edges per sent word. When no sample is held at a slot boundary, `bclk` stays low with no edges until one arrives.
- R9: In normal mode, a slot boundary with no held sample sends the previous word again and sets `uflow`. `uflow` stays set until `uflow_clr` is pulsed, and it is not set while samples arrive in time.
- R10: `smp_ready` is 1 exactly when the holding register is empty. After reset `bclk`, `wsel`, `sdata` and `uflow` are 0, and `bclk` stays low until the first sample has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len_code | input | 3 | Data word length code |
| cfg_right_just | input | 1 | 1: word taken from the low end of the sample |
| cfg_zero_delay | input | 1 | 1: no lag between word select and MSB |
| cfg_compress | input | 1 | Compressed mode (forces no lag) |
| cfg_burst | input | 1 | Burst clocking, active only with compressed mode |
| smp_valid | input | 1 | Sample offered |
| smp_data | input | 32 | Sample value |
| smp_ready | output | 1 | Holding register empty |
| uflow_clr | input | 1 | Clears the underflow flag |
| bclk | output | 1 | Serial bit clock |
| wsel | output | 1 | Word select, 0 left, 1 right |
| sdata | output | 1 | Serial data |
| uflow | output | 1 | Sticky underflow flag |

## Verification
The bench decodes the serial line on its own, using the rising bit-clock edges. It rebuilds each word from the word-select changes and the lag that the requirements call for. A design that applied the lag in compressed mode, or left it out in normal mode, would show every word shifted by one bit. The 32-bit word with lag puts its LSB in the same bit period as the next word-select change. A counter that wrapped at N instead of 32 would therefore lose or corrupt that last bit. Junk bits outside the selected field catch extraction from the wrong end of the sample or a bad mask. Counting clock edges across a deliberate gap in burst mode catches a clock that keeps running without data. Draining the holding register in normal mode catches a design that sends zeros instead of the previous word, or that does not latch the underflow flag.

// File: rtl/sat_pkg.sv
// Shared constants and the word-length decode used by the transmitter.
package sat_pkg;
    localparam int REG_W = 32;   // width of the parallel sample
    localparam int LEN_W = 6;    // width of bit counts and word lengths

    // Map the length code to a bit count; unlisted codes fall back to full width.
    function automatic logic [LEN_W-1:0] word_bits(input logic [2:0] code);
        case (code)
            3'b010:  word_bits = LEN_W'(18);
            3'b011:  word_bits = LEN_W'(20);
            3'b100:  word_bits = LEN_W'(22);
            3'b101:  word_bits = LEN_W'(24);
            default: word_bits = LEN_W'(REG_W);
        endcase
    endfunction
endpackage

// File: rtl/sat_hold_reg.sv
// One-entry holding register between the sample source and the serializer.
// Assumes pop is raised only while out_valid is 1.
module sat_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         pop,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic         full_q;
    logic [W-1:0] data_q;

    assign in_ready  = !full_q;
    assign out_valid = full_q;
    assign out_data  = data_q;

    // Capture a sample when empty; release it when the serializer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (in_valid && !full_q) begin
            full_q <= 1'b1;
            data_q <= in_data;
        end else if (pop) begin
            full_q <= 1'b0;
        end
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !pop) |=> (full_q && $stable(data_q)));  // R10
endmodule

// File: rtl/sat_align.sv
// Moves the active field of a sample to the top of a word so it can be sent MSB first.
// Bits outside the field are cleared. Assumes nbits is between 1 and W.
module sat_align #(
    parameter int W     = 32,
    parameter int LEN_W = 6
) (
    input  logic [W-1:0]     raw,
    input  logic             right_just,
    input  logic [LEN_W-1:0] nbits,
    output logic [W-1:0]     word
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(W);

    logic [LEN_W-1:0] shamt;
    logic [W-1:0]     top_mask;

    // Work out how far the field sits from the top and which bits to keep.
    always_comb begin
        shamt    = FULL - nbits;
        top_mask = {W{1'b1}} << shamt;
        if (right_just)
            word = raw << shamt;
        else
            word = raw & top_mask;
    end
endmodule

// File: rtl/sat_serializer.sv
// Slot timing, shift register, word-select and bit-clock generation.
// Assumes the configuration stays fixed outside reset. The bit clock toggles on every
// system clock while running, and all data and word-select updates happen on its falling edge.
module sat_serializer #(
    parameter int REG_W     = 32,
    parameter int LEN_W     = 6,
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] nbits,
    input  logic             delay_on,
    input  logic             burst_on,
    input  logic             word_valid,
    input  logic [REG_W-1:0] word,
    input  logic             uflow_clr,
    output logic             pop,
    output logic             sck,
    output logic             ws,
    output logic             sd,
    output logic             uflow
);
    localparam logic [LEN_W-1:0] SLOT_LEN = LEN_W'(SLOT_BITS);
    localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);

    logic             ph, idle, started, dch;
    logic [LEN_W-1:0] dcnt;
    logic [REG_W-1:0] shreg, last_word;
    logic             ws_q, sd_q, uf_q;

    logic [LEN_W-1:0] slot_len, dcnt_inc;
    logic             at_end, fall, exit_idle, preamble, bnd_go, go_idle, step;
    logic [REG_W-1:0] load_word;

    // Decide what the next falling edge, or the exit from idle, does.
    always_comb begin
        slot_len  = burst_on ? nbits : SLOT_LEN;
        dcnt_inc  = dcnt + ONE;
        at_end    = (dcnt >= slot_len - ONE);
        fall      = !idle && ph;
        exit_idle = idle && (word_valid || (started && !burst_on));
        preamble  = exit_idle && !started && delay_on;
        bnd_go    = (exit_idle && !preamble) || (fall && at_end && (word_valid || !burst_on));
        go_idle   = fall && at_end && burst_on && !word_valid;
        step      = fall && !at_end;
        load_word = word_valid ? word : last_word;
    end

    assign pop   = bnd_go && word_valid;
    assign sck   = ph;
    assign ws    = ws_q;
    assign sd    = sd_q;
    assign uflow = uf_q;

    // Advance clock phase, slot position, shifter and line outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= 1'b0;
            idle      <= 1'b1;
            started   <= 1'b0;
            dch       <= 1'b1;
            dcnt      <= SLOT_LEN - ONE;
            shreg     <= '0;
            last_word <= '0;
            ws_q      <= 1'b0;
            sd_q      <= 1'b0;
            uf_q      <= 1'b0;
        end else begin
            ph <= idle ? 1'b0 : ~ph;
            if (exit_idle)
                idle <= 1'b0;
            else if (go_idle)
                idle <= 1'b1;
            if (uflow_clr)
                uf_q <= 1'b0;
            if (preamble) begin
                started <= 1'b1;
                ws_q    <= 1'b0;
                sd_q    <= 1'b0;
            end
            if (bnd_go) begin
                started   <= 1'b1;
                dcnt      <= '0;
                dch       <= ~dch;
                ws_q      <= ~dch;
                sd_q      <= load_word[REG_W-1];
                shreg     <= load_word << 1;
                last_word <= load_word;
                if (!word_valid)
                    uf_q <= 1'b1;
            end
            if (step) begin
                dcnt  <= dcnt_inc;
                shreg <= shreg << 1;
                sd_q  <= (dcnt_inc < nbits) ? shreg[REG_W-1] : 1'b0;
                ws_q  <= (delay_on && (dcnt_inc == slot_len - ONE)) ? ~dch : dch;
            end
            if (go_idle)
                sd_q <= 1'b0;
        end
    end

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_q) |-> ($fell(ph) || $past(idle)));  // R4
    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws_q) |-> ($fell(ph) || $past(idle)));  // R4
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && (dcnt >= nbits)) |-> !sd_q);  // R5
    AST_IDLE_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !ph);  // R8
    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_q && !uflow_clr) |=> uf_q);  // R9
    AST_BURST_NO_UF: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_on && !uf_q) |=> !uf_q);  // R8
endmodule

// File: rtl/sat_tx.sv
// Top of the serial audio word transmitter: holding register, field alignment and serializer.
// Assumes the cfg_* inputs change only while rst_n is low.
module sat_tx
    import sat_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_len_code,
    input  logic             cfg_right_just,
    input  logic             cfg_zero_delay,
    input  logic             cfg_compress,
    input  logic             cfg_burst,
    input  logic             smp_valid,
    input  logic [REG_W-1:0] smp_data,
    output logic             smp_ready,
    input  logic             uflow_clr,
    output logic             bclk,
    output logic             wsel,
    output logic             sdata,
    output logic             uflow
);
    logic [LEN_W-1:0] nbits;
    logic             delay_on, burst_on;
    logic             hold_valid, hold_pop;
    logic [REG_W-1:0] hold_data, aligned;

    // Resolve the mode inputs into word length, lag and clock gating.
    always_comb begin
        nbits    = word_bits(cfg_len_code);
        delay_on = !cfg_zero_delay && !cfg_compress;
        burst_on = cfg_burst && cfg_compress;
    end

    sat_hold_reg #(.W(REG_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_data   (smp_data),
        .in_ready  (smp_ready),
        .pop       (hold_pop),
        .out_valid (hold_valid),
        .out_data  (hold_data)
    );

    sat_align #(.W(REG_W), .LEN_W(LEN_W)) u_align (
        .raw        (hold_data),
        .right_just (cfg_right_just),
        .nbits      (nbits),
        .word       (aligned)
    );

    sat_serializer #(.REG_W(REG_W), .LEN_W(LEN_W), .SLOT_BITS(SLOT_BITS)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .nbits      (nbits),
        .delay_on   (delay_on),
        .burst_on   (burst_on),
        .word_valid (hold_valid),
        .word       (aligned),
        .uflow_clr  (uflow_clr),
        .pop        (hold_pop),
        .sck        (bclk),
        .ws         (wsel),
        .sd         (sdata),
        .uflow      (uflow)
    );

    AST_POP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        hold_pop |-> !smp_ready);  // R10
endmodule

// File: tb/tb_sat_tx.sv
module tb_sat_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_len_code = 3'b011;
    logic        cfg_right_just = 1'b0, cfg_zero_delay = 1'b0, cfg_compress = 1'b0, cfg_burst = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        smp_ready;
    logic        uflow_clr = 1'b0;
    logic        bclk, wsel, sdata, uflow;

    always #5 clk = ~clk;

    sat_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_len_code(cfg_len_code), .cfg_right_just(cfg_right_just),
        .cfg_zero_delay(cfg_zero_delay), .cfg_compress(cfg_compress), .cfg_burst(cfg_burst),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready), .uflow_clr(uflow_clr),
        .bclk(bclk), .wsel(wsel), .sdata(sdata), .uflow(uflow)
    );

    int checks = 0;
    int errors = 0;

    // scoreboard state
    logic [31:0] exp_q[$];
    logic [31:0] last_exp, cur_exp, got;
    int          m_n = 20;
    bit          m_del = 1'b1, m_burst = 1'b0;
    string       m_tag = "";
    logic        sck_prev = 1'b0, ws_prev = 1'b1, pend = 1'b0, pad = 1'b0;
    int          dk = 99;
    int          rises = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_bits(input logic [31:0] d, input int n, input bit right);
        if (n == 32) return d;
        if (right) return d & ((32'h1 << n) - 32'h1);
        return d >> (32 - n);
    endfunction

    // Monitor: decode the line at each rising bit-clock edge and compare whole words.
    always @(negedge clk) begin
        if (!rst_n) begin
            sck_prev = 1'b0;
        end else begin
            if (bclk && !sck_prev) begin
                rises++;
                if ((!m_del && (wsel != ws_prev)) || (m_del && pend)) dk = 0;
                else if (dk < 99) dk++;
                pend    = (wsel != ws_prev);
                ws_prev = wsel;
                if (dk == 0) begin
                    if (exp_q.size() > 0) cur_exp = exp_q.pop_front();
                    else cur_exp = last_exp;
                    last_exp = cur_exp;
                    got = '0;
                    pad = 1'b0;
                end
                if (dk < m_n) got = {got[30:0], sdata};
                else if (dk < 32) pad = pad | sdata;
                if (dk == m_n - 1) chk(got == cur_exp, {"R4 word ", m_tag}, got, cur_exp);
                if (!m_burst && dk == 31) chk(pad == 1'b0, "R5 padding", {31'b0, pad}, 32'h0);
            end
            sck_prev = bclk;
        end
    end

    // Driver: offer one sample and record its expected serial word at the handshake.
    task automatic push(input logic [31:0] d);
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = d;
        @(posedge clk);
        exp_q.push_back(exp_bits(d, m_n, cfg_right_just));
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic start_phase(input logic [2:0] code, input bit right, input bit zd, input bit cp,
                               input bit bu, input int n, input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_len_code = code; cfg_right_just = right; cfg_zero_delay = zd;
        cfg_compress = cp; cfg_burst = bu;
        m_n = n; m_del = !zd && !cp; m_burst = bu && cp; m_tag = tag;
        exp_q.delete(); last_exp = '0; ws_prev = 1'b1; pend = 1'b0; dk = 99; rises = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic feed(input int cnt, input logic [31:0] seed);
        for (int i = 0; i < cnt; i++)
            push((seed * 32'(i + 3)) ^ {seed[15:0], seed[31:16]} ^ 32'(i * 32'h01234567));
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        repeat (80) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Phase 1: 20-bit, top field, one-bit lag, plus reset, ready and underflow checks
        start_phase(3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 20, "R1 R2 R6");
        @(negedge clk);
        chk({bclk, wsel, sdata, uflow} == 4'b0, "R10 reset outputs", {28'b0, bclk, wsel, sdata, uflow}, 32'h0);
        chk(smp_ready == 1'b1, "R10 ready after reset", {31'b0, smp_ready}, 32'h1);
        repeat (20) @(negedge clk);
        chk(rises == 0, "R10 no clock before first sample", rises, 0);
        push(32'hA5C3_F00F);
        chk(smp_ready == 1'b0, "R10 ready low when full", {31'b0, smp_ready}, 32'h0);
        feed(3, 32'h1357_2468);
        chk(uflow == 1'b0, "R9 no underflow while fed", {31'b0, uflow}, 32'h0);
        drain();
        repeat (150) @(negedge clk);
        chk(uflow == 1'b1, "R9 underflow set after drain", {31'b0, uflow}, 32'h1);
        push(32'h0F1E_2D3C);
        uflow_clr = 1'b1;
        @(negedge clk);
        uflow_clr = 1'b0;
        chk(uflow == 1'b0, "R9 underflow cleared", {31'b0, uflow}, 32'h0);
        drain();

        start_phase(3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 20, "R3 R6 no lag");
        feed(3, 32'hDEAD_BEEF);
        drain();

        start_phase(3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 18, "R1 R3 18-bit");
        feed(3, 32'hC0FF_EE11);
        drain();

        start_phase(3'b100, 1'b0, 1'b1, 1'b0, 1'b0, 22, "R1 R2 22-bit");
        feed(3, 32'h8BAD_F00D);
        drain();

        start_phase(3'b101, 1'b1, 1'b0, 1'b0, 1'b0, 24, "R1 R3 24-bit");
        feed(3, 32'h7E57_0A0B);
        drain();

        start_phase(3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 32, "R3 R5 32-bit lag");
        feed(4, 32'hF00D_CAFE);
        drain();

        start_phase(3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 32, "R1 reserved code");
        feed(3, 32'h2468_ACE1);
        drain();

        start_phase(3'b101, 1'b0, 1'b0, 1'b1, 1'b0, 24, "R7 compressed");
        feed(3, 32'h5A5A_0FF0);
        drain();

        // Burst clocking: edges only with data, silent gap when starved
        start_phase(3'b010, 1'b1, 1'b0, 1'b1, 1'b1, 18, "R8 burst");
        feed(3, 32'h3141_5926);
        drain();
        begin
            int snap;
            snap = rises;
            repeat (100) @(negedge clk);
            chk(rises == snap && bclk == 1'b0, "R8 clock idle in gap", rises, snap);
        end
        feed(2, 32'h2718_2818);
        drain();
        chk(rises == 5 * 18, "R8 edges per word", rises, 5 * 18);
        chk(uflow == 1'b0, "R8 no underflow in burst", {31'b0, uflow}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule